// File: doc/BRIEF.md
# Strobe-Qualified Bus Target with Wait-State Ready

This block is a memory-mapped target on a host bus that uses active-low read and write strobes, a chip select and an open-drain-style ready line. All of its logic runs on the bus clock. An access begins at the first bus-clock rising edge on which chip select and one strobe are both low. On that edge the block samples the address, the memory/register select, the high-byte enable and the clock-ratio setting. It then holds ready low for a wait period and releases it by driving ready high.

The wait period depends on a 2-bit setting that gives the ratio between the slow internal memory clock and the bus clock: divide by 1, 2, 3 or 4. Write data goes into a one-entry write buffer on a fixed edge. It is committed to storage only when ready is released. Read data comes from either a small register bank or a memory array, and each has its own read multiplexer. The ready driver and the data-bus driver are modelled as a value plus a separate output enable. Both enables stay low whenever chip select is high.

Top module: `strobe_tgt_top`

## Requirements
- R1: While reset is held and after it is released, readyOut, readyOe and dataOe are 0, and every storage word reads back as 0.
- R2: addr, memSel and hiByteN are sampled only on the first qualified edge (csN=0 and rdN=0 or wrN=0). Changes to them later in the access have no effect.
- R3: readyOut stays 0 through qualified edge N-1 and is 1 after qualified edge N, where N is 6, 9, 11 or 15 for ratio values 0, 1, 2 or 3. The ratio is sampled on the first qualified edge.
- R4: Write data is taken from dataIn on the third qualified edge. Values of dataIn after that edge do not change what is stored.
- R5: The low byte (bits 7:0) is written only when addr bit 0 is 0. The high byte (bits 15:8) is written only when hiByteN is 0. Any lane that is not enabled keeps its old value.
- R6: memSel=1 selects a 64-word memory and memSel=0 selects a 16-word register bank. The word index is the address bits above bit 0, modulo the depth. The two stores are independent.
- R7: During a read, with csN=0, rdN=0 and wrN=1, dataOe is 1. Once readyOut is 1, dataOut holds the full 16-bit word that was addressed.
- R8: readyOe is 1 exactly while csN=0 and a strobe is low. dataOe is 0 whenever csN=1 or rdN=1.
- R9: If the strobe is released before ready is released, the access is aborted. Storage is left unchanged, readyOut stays 0, and the block returns to idle so the next access works normally.
- R10: After the strobe is released at the end of an access, readyOut is 0 by the next bus-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| addr | input | 17 | Byte address |
| memSel | input | 1 | 1 = memory array, 0 = register bank |
| hiByteN | input | 1 | High-byte enable, active low |
| ratio | input | 2 | Memory-clock divider setting (0..3 = divide by 1..4) |
| dataIn | input | 16 | Write data from the bus |
| dataOut | output | 16 | Read data to the bus |
| dataOe | output | 1 | Data-bus output enable |
| readyOut | output | 1 | Ready value, 0 = wait, 1 = released |
| readyOe | output | 1 | Ready output enable |

## Verification
The two enables follow csN and the strobes without any register in the path, so the bench checks them one nanosecond after it changes those inputs. readyOut and the read word both come from registers that update on qualified edge N. The bench therefore counts edges from the access start and samples on the falling edge after edge N-1, expecting 0, and again after edge N, expecting 1 and the word from its own model. Storage effects, such as byte lanes, the edge-3 data capture, address changes after edge 1 and aborted writes, cannot be seen at the ports until a later read. The bench checks each of them by reading the same location back and comparing the result with a model that applies the write only on a completed access.

// File: rtl/strobe_tgt_pkg.sv
package strobe_tgt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_DONE   = 2'd2
  } tgtState_t;

  // Control-to-datapath strobes, each valid for one bus-clock edge.
  typedef struct packed {
    logic capAddr;  // first qualified edge: sample address side
    logic capData;  // third qualified edge: fill write buffer
    logic commit;   // final wait edge of a write
    logic latchRd;  // final wait edge of a read
  } tgtStrb_t;

  // Bus-clock edges from access start until ready is released.
  function automatic int unsigned waitEdges(input logic [1:0] ratioSel);
    case (ratioSel)
      2'd0:    return 6;
      2'd1:    return 9;
      2'd2:    return 11;
      default: return 15;
    endcase
  endfunction

endpackage

// File: rtl/strobe_tgt_ctrl.sv
module strobe_tgt_ctrl
  import strobe_tgt_pkg::*;
#(
  parameter int CntW = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     csN,
  input  logic     rdN,
  input  logic     wrN,
  input  logic [1:0] ratio,
  output tgtStrb_t strb,
  output logic     readyOut
);

  tgtState_t state;
  logic [CntW-1:0] cnt;
  logic [CntW-1:0] limit;
  logic isWr;
  logic qual;
  logic lastEdge;

  assign qual     = !csN && (!rdN || !wrN);
  assign lastEdge = (state == ST_ACTIVE) && qual && (cnt == limit - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      limit <= '0;
      isWr  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (qual) begin
          state <= ST_ACTIVE;
          cnt   <= CntW'(1);
          limit <= CntW'(waitEdges(ratio));
          isWr  <= !wrN;
        end
        ST_ACTIVE: begin
          if (!qual) begin
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
            if (lastEdge) state <= ST_DONE;
          end
        end
        ST_DONE: if (!qual) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.capAddr = (state == ST_IDLE) && qual;
    strb.capData = (state == ST_ACTIVE) && qual && isWr && (cnt == CntW'(2));
    strb.commit  = lastEdge && isWr;
    strb.latchRd = lastEdge && !isWr;
  end

  assign readyOut = (state == ST_DONE);

  // R3
  ready_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(readyOut) |-> ($past(cnt) == limit - 1'b1));

  // R3
  cnt_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACTIVE) |-> (cnt < limit));

  // R9
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_ACTIVE) && !qual) |=> ((state == ST_IDLE) && !readyOut));

  // R10
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (readyOut && !qual) |=> !readyOut);

endmodule

// File: rtl/strobe_tgt_dp.sv
module strobe_tgt_dp
  import strobe_tgt_pkg::*;
#(
  parameter int AddrW    = 17,
  parameter int DataW    = 16,
  parameter int MemWords = 64,
  parameter int RegWords = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tgtStrb_t         strb,
  input  logic [AddrW-1:0] addr,
  input  logic             memSel,
  input  logic             hiByteN,
  input  logic [DataW-1:0] dataIn,
  output logic [DataW-1:0] rdData
);

  localparam int Lanes   = DataW / 8;
  localparam int MemIdxW = $clog2(MemWords);
  localparam int RegIdxW = $clog2(RegWords);

  logic [AddrW-1:0] addrQ;
  logic             selQ;
  logic             hbeNQ;
  logic [DataW-1:0] wbData;
  logic [Lanes-1:0] laneEn;
  logic [DataW-1:0] memRd;
  logic [DataW-1:0] regRd;
  logic [MemIdxW-1:0] memIdx;
  logic [RegIdxW-1:0] regIdx;
  logic unusedAddrBits;

  assign memIdx = addrQ[MemIdxW:1];
  assign regIdx = addrQ[RegIdxW:1];
  assign unusedAddrBits = ^addrQ[AddrW-1:MemIdxW+1];

  // Lane 0 follows address bit 0, the top lane follows the high-byte enable.
  always_comb begin
    laneEn = '0;
    laneEn[0]       = !addrQ[0];
    laneEn[Lanes-1] = !hbeNQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      selQ   <= 1'b0;
      hbeNQ  <= 1'b1;
      wbData <= '0;
      rdData <= '0;
    end else begin
      if (strb.capAddr) begin
        addrQ <= addr;
        selQ  <= memSel;
        hbeNQ <= hiByteN;
      end
      if (strb.capData) wbData <= dataIn;
      if (strb.latchRd) rdData <= selQ ? memRd : regRd;
    end
  end

  for (genvar g = 0; g < Lanes; g++) begin : gLane
    logic [7:0] memB [MemWords];
    logic [7:0] regB [RegWords];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int i = 0; i < MemWords; i++) memB[i] <= '0;
      end else if (strb.commit && selQ && laneEn[g]) begin
        memB[memIdx] <= wbData[g*8 +: 8];
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int i = 0; i < RegWords; i++) regB[i] <= '0;
      end else if (strb.commit && !selQ && laneEn[g]) begin
        regB[regIdx] <= wbData[g*8 +: 8];
      end
    end

    assign memRd[g*8 +: 8] = memB[memIdx];
    assign regRd[g*8 +: 8] = regB[regIdx];
  end

  // R4
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.capData) |-> $stable(wbData));

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.capAddr) |-> ($stable(addrQ) && $stable(selQ) && $stable(hbeNQ)));

  // R7
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.latchRd) |-> $stable(rdData));

endmodule

// File: rtl/strobe_tgt_top.sv
module strobe_tgt_top
  import strobe_tgt_pkg::*;
#(
  parameter int AddrW    = 17,
  parameter int DataW    = 16,
  parameter int MemWords = 64,
  parameter int RegWords = 16,
  parameter int CntW     = 4
) (
  input  logic             busClk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             rdN,
  input  logic             wrN,
  input  logic [AddrW-1:0] addr,
  input  logic             memSel,
  input  logic             hiByteN,
  input  logic [1:0]       ratio,
  input  logic [DataW-1:0] dataIn,
  output logic [DataW-1:0] dataOut,
  output logic             dataOe,
  output logic             readyOut,
  output logic             readyOe
);

  tgtStrb_t strb;

  strobe_tgt_ctrl #(.CntW(CntW)) ctrl_i (
    .clk     (busClk),
    .rstN    (rstN),
    .csN     (csN),
    .rdN     (rdN),
    .wrN     (wrN),
    .ratio   (ratio),
    .strb    (strb),
    .readyOut(readyOut)
  );

  strobe_tgt_dp #(
    .AddrW   (AddrW),
    .DataW   (DataW),
    .MemWords(MemWords),
    .RegWords(RegWords)
  ) dp_i (
    .clk    (busClk),
    .rstN   (rstN),
    .strb   (strb),
    .addr   (addr),
    .memSel (memSel),
    .hiByteN(hiByteN),
    .dataIn (dataIn),
    .rdData (dataOut)
  );

  assign readyOe = !csN && (!rdN || !wrN);
  assign dataOe  = !csN && !rdN && wrN;

  // R8
  oe_cs_chk: assert property (@(posedge busClk) disable iff (!rstN)
    csN |-> (!readyOe && !dataOe));

  // R1
  reset_quiet_chk: assert property (@(posedge busClk)
    !rstN |-> !readyOut);

endmodule

// File: tb/strobe_tgt_top_tb_top.sv
module strobe_tgt_top_tb_top;

  logic clk = 1'b0;
  logic rstN;
  logic csN, rdN, wrN, memSel, hiByteN;
  logic [16:0] addr;
  logic [1:0]  ratio;
  logic [15:0] dataIn;
  logic [15:0] dataOut;
  logic dataOe, readyOut, readyOe;

  int testCnt = 0;
  int failCnt = 0;

  logic [15:0] memModel [64];
  logic [15:0] regModel [16];

  always #4 clk = ~clk;

  strobe_tgt_top dut_i (
    .busClk  (clk),
    .rstN    (rstN),
    .csN     (csN),
    .rdN     (rdN),
    .wrN     (wrN),
    .addr    (addr),
    .memSel  (memSel),
    .hiByteN (hiByteN),
    .ratio   (ratio),
    .dataIn  (dataIn),
    .dataOut (dataOut),
    .dataOe  (dataOe),
    .readyOut(readyOut),
    .readyOe (readyOe)
  );

  function automatic int expEdges(input logic [1:0] r);
    case (r)
      2'd0: return 6;
      2'd1: return 9;
      2'd2: return 11;
      default: return 15;
    endcase
  endfunction

  function automatic logic [15:0] mergeWord(input logic [15:0] old, input logic [15:0] d,
                                            input logic a0, input logic hbeN);
    logic [15:0] w;
    w = old;
    if (!a0)   w[7:0]  = d[7:0];
    if (!hbeN) w[15:8] = d[15:8];
    return w;
  endfunction

  function automatic logic [15:0] modelRead(input logic sel, input logic [16:0] a);
    return sel ? memModel[a[6:1]] : regModel[a[4:1]];
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One access starting at a falling edge. abortAt > 0 releases the strobe
  // after that many qualified edges, before ready is due.
  task automatic doAccess(input bit isWr, input bit sel, input logic [16:0] a,
                          input bit hbeN, input logic [15:0] d, input logic [1:0] r,
                          input int abortAt);
    int n;
    logic [15:0] expRd;
    n = expEdges(r);
    expRd = modelRead(sel, a);
    csN = 1'b0; memSel = sel; addr = a; hiByteN = hbeN; dataIn = d; ratio = r;
    if (isWr) wrN = 1'b0; else rdN = 1'b0;
    #1;
    check("R8 readyOe on strobe", {15'd0, readyOe}, 16'd1);
    check("R7 dataOe on read", {15'd0, dataOe}, {15'd0, !isWr});
    for (int e = 1; e <= n; e++) begin
      @(posedge clk); @(negedge clk);
      if (e == 1) begin  // R2: later address side changes ignored
        addr = 17'($urandom); memSel = ~sel; hiByteN = ~hbeN; ratio = ~r;
      end
      if (e == 3) dataIn = 16'($urandom);  // R4: data after edge 3 ignored
      if (abortAt == e) begin
        csN = 1'b1; rdN = 1'b1; wrN = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R9 no ready after abort", {15'd0, readyOut}, 16'd0);
        return;
      end
      check("R3 ready timing", {15'd0, readyOut}, {15'd0, (e == n)});
    end
    if (!isWr) check("R7 read data", dataOut, expRd);
    else if (sel) memModel[a[6:1]] = mergeWord(memModel[a[6:1]], d, a[0], hbeN);
    else regModel[a[4:1]] = mergeWord(regModel[a[4:1]], d, a[0], hbeN);
    csN = 1'b1; rdN = 1'b1; wrN = 1'b1;
    #1;
    check("R8 enables off with cs high", {14'd0, readyOe, dataOe}, 16'd0);
    @(posedge clk); @(negedge clk);
    check("R10 ready low after release", {15'd0, readyOut}, 16'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 64; i++) memModel[i] = '0;
    for (int i = 0; i < 16; i++) regModel[i] = '0;
    rstN = 1'b0; csN = 1'b1; rdN = 1'b1; wrN = 1'b1; memSel = 1'b0;
    hiByteN = 1'b1; addr = '0; ratio = '0; dataIn = '0;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {13'd0, readyOut, readyOe, dataOe}, 16'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 outputs after reset", {13'd0, readyOut, readyOe, dataOe}, 16'd0);

    // R1: untouched words read zero
    doAccess(0, 1, 17'h0040, 0, 0, 2'd0, 0);
    doAccess(0, 0, 17'h0006, 0, 0, 2'd1, 0);

    // R3: every ratio, full-word writes and readbacks
    for (int r = 0; r < 4; r++) begin
      doAccess(1, 1, 17'(r * 2), 0, 16'hA5C0 + 16'(r), 2'(r), 0);
      doAccess(0, 1, 17'(r * 2), 0, 0, 2'(3 - r), 0);
    end

    // R5: byte lanes
    doAccess(1, 1, 17'h0020, 0, 16'h1234, 2'd0, 0);
    doAccess(1, 1, 17'h0020, 1, 16'hAB56, 2'd0, 0);  // low byte only
    doAccess(0, 1, 17'h0020, 0, 0, 2'd0, 0);
    doAccess(1, 1, 17'h0021, 0, 16'hCD99, 2'd1, 0);  // high byte only
    doAccess(0, 1, 17'h0020, 0, 0, 2'd0, 0);
    doAccess(1, 1, 17'h0021, 1, 16'hFFFF, 2'd2, 0);  // no lane
    doAccess(0, 1, 17'h0020, 0, 0, 2'd0, 0);

    // R6: same index in both stores
    doAccess(1, 0, 17'h000A, 0, 16'h0BAD, 2'd0, 0);
    doAccess(1, 1, 17'h000A, 0, 16'h600D, 2'd0, 0);
    doAccess(0, 0, 17'h000A, 0, 0, 2'd0, 0);
    doAccess(0, 1, 17'h000A, 0, 0, 2'd0, 0);

    // R9: aborted writes leave storage alone
    doAccess(1, 1, 17'h000A, 0, 16'hDEAD, 2'd0, 5);
    doAccess(1, 0, 17'h000A, 0, 16'hBEEF, 2'd3, 1);
    doAccess(0, 1, 17'h000A, 0, 0, 2'd0, 0);
    doAccess(0, 0, 17'h000A, 0, 0, 2'd0, 0);

    // Random mix
    for (int k = 0; k < 120; k++) begin
      bit isWr, sel, hbeN;
      logic [16:0] a;
      sel  = 1'($urandom);
      isWr = 1'($urandom);
      hbeN = 1'($urandom);
      a    = sel ? 17'($urandom % 128) : 17'($urandom % 32);
      doAccess(isWr, sel, a, hbeN, 16'($urandom), 2'($urandom),
               ($urandom % 8 == 0) ? int'($urandom % 5) + 1 : 0);
    end

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule